// File: doc/BRIEF.md
# Pipelined Binary-Tree Memory Access Switch

This block joins a single requester to a bank of `2**ADDR_W` storage words through a binary tree of steering switches. The words sit in the tree's leaves. A request holds a command (read or write), a word address and write data. Each switch level looks at one address bit, starting from the most significant one, and passes the request to one of its two children. When the request reaches the addressed leaf, that leaf updates its word (write) or sends its word back toward the root (read).

Every link works in both directions and has a register in each direction. The forward path has one register per switch level. The return path has one register per leaf and one per switch level. The root can therefore take a new request in every cycle, and several requests and responses can be moving through the tree at once. Each switch records which side it sent every read to. When the matching reply comes back, the switch takes it only from that side, so a reply follows the same path as its request in reverse. The tree has `2**ADDR_W - 1` switches and `2**ADDR_W` leaves, which is `2*2**ADDR_W - 1` nodes in all.

Top module: `bintree_mem`

## Requirements
- R1: A request with address `a` acts on word `a` and on no other word. The switch at level `i` (the root is level 0) looks at address bit `ADDR_W-1-i`. A value of 0 sends the request to the upper child and a value of 1 sends it to the lower child.
- R2: A write (`req_valid=1`, `req_write=1`) stores `req_wdata` in the addressed word and never raises `rsp_valid`.
- R3: A read (`req_valid=1`, `req_write=0`) accepted at the end of cycle `c` drives `rsp_valid=1` in cycle `c + 2*ADDR_W + 1`, with the addressed word on `rsp_rdata`.
- R4: A new request can be accepted in every cycle. Reads issued back to back give responses in consecutive cycles, in issue order.
- R5: A response is accepted only from the child the read was steered to. No cycle shows `rsp_valid=1` unless a read is due in that cycle.
- R6: After reset every word reads as zero, and `rsp_valid` stays 0 while reset is asserted.
- R7: A read issued in the cycle after a write to the same word returns the new data. A write issued in the cycle after a read of the same word does not change what that read returns.
- R8: A read does not change the word it reads, whatever value `req_wdata` has.
- R9: While `req_valid=0`, the values on `req_write`, `req_addr` and `req_wdata` have no effect on any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Data for a write |
| rsp_valid | output | 1 | Read data is valid in this cycle |
| rsp_rdata | output | DATA_W | Data returned by a read |

## Verification
The overlap that matters most is a new request travelling down through a switch in the same cycle that an older read reply travels up through it. The same word can also be written at its leaf in the cycle just after it was read, or just before. The bench creates these cases with an exhaustive sweep of write/read address pairs issued in consecutive cycles, followed by a long mixed stream from a shift-register generator. Each reply is judged against a bench memory model. The check looks at the exact cycle the reply is due, and at every other cycle it also checks that `rsp_valid` is low.

// File: rtl/bintree_pkg.sv
package bintree_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

endpackage

// File: rtl/bintree_leaf.sv
module bintree_leaf
    import bintree_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int WORD_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              in_cmd,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              out_rv,
    output logic [DATA_W-1:0] out_rd
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              rv;
        logic [DATA_W-1:0] rd;
    } leaf_state_t;

    leaf_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.rv = 1'b0;
        case (in_cmd)
            CMD_WRITE: s_d.word = in_wdata;
            CMD_READ: begin
                s_d.rv = 1'b1;
                s_d.rd = s_q.word;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_rv = s_q.rv;
    assign out_rd = s_q.rd;

    AST_LEAF_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmd != CMD_IDLE) |-> (in_addr == ADDR_W'(WORD_IDX))); // R1

    AST_LEAF_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmd == CMD_WRITE) |=> (s_q.word == $past(in_wdata))); // R2

endmodule

// File: rtl/bintree_switch.sv
module bintree_switch
    import bintree_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int LEVEL  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    // request from parent
    input  cmd_e              in_cmd,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    // request to upper child (address bit 0)
    output cmd_e              up_cmd,
    output logic [ADDR_W-1:0] up_addr,
    output logic [DATA_W-1:0] up_wdata,
    // request to lower child (address bit 1)
    output cmd_e              dn_cmd,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    // returns from children
    input  logic              up_rv,
    input  logic [DATA_W-1:0] up_rd,
    input  logic              dn_rv,
    input  logic [DATA_W-1:0] dn_rd,
    // return to parent
    output logic              out_rv,
    output logic [DATA_W-1:0] out_rd
);

    localparam int BIT  = ADDR_W - 1 - LEVEL;
    localparam int HIST = 2 * (ADDR_W - LEVEL) - 1;

    typedef struct packed {
        cmd_e              cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [HIST-1:0]   rd_hist;
        logic [HIST-1:0]   dir_hist;
        logic              rv;
        logic [DATA_W-1:0] rd;
    } sw_state_t;

    sw_state_t s_d, s_q;
    logic      due_rd;
    logic      due_dir;

    assign due_rd  = s_q.rd_hist[HIST-1];
    assign due_dir = s_q.dir_hist[HIST-1];

    always_comb begin
        s_d       = s_q;
        s_d.cmd   = in_cmd;
        s_d.addr  = in_addr;
        s_d.wdata = in_wdata;
        for (int j = HIST - 1; j > 0; j--) begin
            s_d.rd_hist[j]  = s_q.rd_hist[j-1];
            s_d.dir_hist[j] = s_q.dir_hist[j-1];
        end
        s_d.rd_hist[0]  = (s_q.cmd == CMD_READ);
        s_d.dir_hist[0] = s_q.addr[BIT];
        s_d.rv = due_rd & (due_dir ? dn_rv : up_rv);
        s_d.rd = due_dir ? dn_rd : up_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign up_cmd   = (s_q.cmd != CMD_IDLE && !s_q.addr[BIT]) ? s_q.cmd : CMD_IDLE;
    assign dn_cmd   = (s_q.cmd != CMD_IDLE &&  s_q.addr[BIT]) ? s_q.cmd : CMD_IDLE;
    assign up_addr  = s_q.addr;
    assign dn_addr  = s_q.addr;
    assign up_wdata = s_q.wdata;
    assign dn_wdata = s_q.wdata;
    assign out_rv   = s_q.rv;
    assign out_rd   = s_q.rd;

    AST_RETURN_ON_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        due_rd |-> (due_dir ? dn_rv : up_rv)); // R5

    AST_NO_STRAY_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        !due_rd |-> !(up_rv || dn_rv)); // R5

endmodule

// File: rtl/bintree_mem.sv
module bintree_mem
    import bintree_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int WORDS = 1 << ADDR_W;
    localparam int NODES = 2 * WORDS - 1;
    localparam int LAT   = 2 * ADDR_W + 1;
    localparam int CNT_W = $clog2(LAT + 1) + 1;

    // heap numbering: node n has children 2n (upper) and 2n+1 (lower)
    cmd_e              lnk_cmd   [1:NODES];
    logic [ADDR_W-1:0] lnk_addr  [1:NODES];
    logic [DATA_W-1:0] lnk_wdata [1:NODES];
    logic              ret_v     [1:NODES];
    logic [DATA_W-1:0] ret_d     [1:NODES];

    assign lnk_cmd[1]   = !req_valid ? CMD_IDLE : (req_write ? CMD_WRITE : CMD_READ);
    assign lnk_addr[1]  = req_addr;
    assign lnk_wdata[1] = req_wdata;

    for (genvar lv = 0; lv < ADDR_W; lv++) begin : g_level
        for (genvar i = 0; i < (1 << lv); i++) begin : g_node
            localparam int N = (1 << lv) + i;
            bintree_switch #(
                .ADDR_W(ADDR_W),
                .DATA_W(DATA_W),
                .LEVEL (lv)
            ) i_switch (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_cmd  (lnk_cmd[N]),
                .in_addr (lnk_addr[N]),
                .in_wdata(lnk_wdata[N]),
                .up_cmd  (lnk_cmd[2*N]),
                .up_addr (lnk_addr[2*N]),
                .up_wdata(lnk_wdata[2*N]),
                .dn_cmd  (lnk_cmd[2*N+1]),
                .dn_addr (lnk_addr[2*N+1]),
                .dn_wdata(lnk_wdata[2*N+1]),
                .up_rv   (ret_v[2*N]),
                .up_rd   (ret_d[2*N]),
                .dn_rv   (ret_v[2*N+1]),
                .dn_rd   (ret_d[2*N+1]),
                .out_rv  (ret_v[N]),
                .out_rd  (ret_d[N])
            );
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_leaf
        bintree_leaf #(
            .ADDR_W  (ADDR_W),
            .DATA_W  (DATA_W),
            .WORD_IDX(w)
        ) i_leaf (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_cmd  (lnk_cmd[WORDS+w]),
            .in_addr (lnk_addr[WORDS+w]),
            .in_wdata(lnk_wdata[WORDS+w]),
            .out_rv  (ret_v[WORDS+w]),
            .out_rd  (ret_d[WORDS+w])
        );
    end

    assign rsp_valid = ret_v[1];
    assign rsp_rdata = ret_d[1];

    // outstanding-read tally guarding the root return
    logic [CNT_W-1:0] inflight_d, inflight_q;
    logic             rd_accept;

    assign rd_accept = req_valid && !req_write;

    always_comb begin
        inflight_d = inflight_q + CNT_W'(rd_accept) - CNT_W'(rsp_valid);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_d;
    end

    AST_RSP_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (inflight_q != '0)); // R3

    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= CNT_W'(LAT)); // R4

endmodule

// File: tb/test_bintree_mem.sv
`timescale 1ns/1ps
module test_bintree_mem;

    localparam int AW  = 3;
    localparam int DW  = 8;
    localparam int M   = 1 << AW;
    localparam int LAT = 2 * AW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [DW-1:0] model [0:M-1];
    bit            exp_v [0:255];
    logic [DW-1:0] exp_d [0:255];
    string         exp_tag [0:255];

    bintree_mem #(.ADDR_W(AW), .DATA_W(DW)) i_bintree_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_out();
        int s = cyc % 256;
        total++;
        if (rsp_valid !== exp_v[s] || (exp_v[s] && rsp_rdata !== exp_d[s])) begin
            bad++;
            $display("FAIL %s cyc=%0d actual v=%0b d=%0h expected v=%0b d=%0h",
                     exp_tag[s], cyc, rsp_valid, rsp_rdata, exp_v[s], exp_d[s]);
        end
        exp_v[s]   = 1'b0;
        exp_tag[s] = "R5";
    endtask

    task automatic op(bit v, bit w, int a, int d, string tag);
        @(negedge clk);
        check_out();
        req_valid = v;
        req_write = w;
        req_addr  = AW'(a);
        req_wdata = DW'(d);
        if (v) begin
            if (w) begin
                model[a] = DW'(d);
            end else begin
                int s = (cyc + LAT) % 256;
                exp_v[s]   = 1'b1;
                exp_d[s]   = model[a];
                exp_tag[s] = tag;
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        for (int k = 0; k < 256; k++) begin
            exp_v[k] = 1'b0; exp_d[k] = '0; exp_tag[k] = "R5";
        end
        for (int a = 0; a < M; a++) model[a] = '0;

        // R6: quiet output while reset is held
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            total++;
            if (rsp_valid !== 1'b0) begin
                bad++;
                $display("FAIL R6 reset actual v=%0b expected v=0", rsp_valid);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R6: all words zero after reset
        for (int a = 0; a < M; a++) op(1, 0, a, 0, "R6");
        // R2 / R1: write distinct values, then read each back
        for (int a = 0; a < M; a++) op(1, 1, a, a * 37 + 5, "R2");
        for (int a = 0; a < M; a++) op(1, 0, a, 0, "R1");
        // R4: back-to-back reads, including the same word repeatedly
        for (int k = 0; k < 4; k++) op(1, 0, 5, 0, "R4");
        for (int a = M - 1; a >= 0; a--) op(1, 0, a, 0, "R4");
        // R7: exhaustive write a then read b in the next cycle
        for (int a = 0; a < M; a++) begin
            for (int b = 0; b < M; b++) begin
                op(1, 1, a, (a * 16 + b) ^ 8'h5A, "R7");
                op(1, 0, b, 0, "R7");
            end
        end
        // R7: read then write the same word in the next cycle
        for (int a = 0; a < M; a++) begin
            op(1, 0, a, 0, "R7");
            op(1, 1, a, 8'hC0 + a, "R7");
        end
        for (int a = 0; a < M; a++) op(1, 0, a, 0, "R7");
        // R9: idle cycles with write-looking garbage on the inputs
        for (int a = 0; a < M; a++) op(0, 1, a, 8'hEE, "R9");
        for (int a = 0; a < M; a++) op(1, 0, a, 0, "R9");
        // R8: reads carrying non-zero write data, then read again
        for (int a = 0; a < M; a++) op(1, 0, a, 8'h99 ^ a, "R8");
        for (int a = 0; a < M; a++) op(1, 0, a, 0, "R8");
        // R3 / R5: long mixed stream
        for (int k = 0; k < 600; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[1:0])
                2'd0:    op(0, lf[2], int'(lf[7:5]), int'(lf[15:8]), "R9");
                2'd1:    op(1, 1, int'(lf[7:5]), int'(lf[15:8]), "R3");
                default: op(1, 0, int'(lf[7:5]), int'(lf[15:8]), "R3");
            endcase
        end
        for (int k = 0; k < LAT + 3; k++) op(0, 0, 0, 0, "R5");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule